// File: doc/BRIEF.md
# Memory Wait-Counter Dependency Tracker

This block keeps count of the memory operations still in flight for a single execution context, split into three classes: vector memory, export, and local/constant/message traffic. Each class has a saturating up/down counter. The counter goes up on an issue strobe and down on a completion strobe. Instruction decode and the memory system stay outside the block and reach it only through these strobes.

A wait works in two steps. First the wait is dispatched, and the context moves from running to waiting. Then the wait executes and loads one threshold per class. Each threshold field has its own width. The all-ones value of a field means "do not wait on this class".

The block computes a satisfied condition. It is true only when the wait has executed and every armed class has no more operations in flight than its threshold. The ready output is registered, so it pulses one cycle after the condition becomes true. On that same edge the thresholds return to unset and the context goes back to running. Illegal threshold loads, counter overflow and counter underflow each set a sticky error flag.

Top module: `mem_wait_tracker`

## Requirements
- R1: After reset all three counts are 0, the context is running (`waiting_o`=0), `ready_o` is 0 and all three error flags are 0.
- R2: Each class counter (strobe bit 0 = vector memory, bit 1 = export, bit 2 = local/constant/message) rises by one on its issue strobe and falls by one on its completion strobe. Both strobes in the same cycle leave it unchanged.
- R3: A counter at 63 that receives a lone issue holds at 63 and sets the sticky `err_ovf_o`.
- R4: A counter at 0 that receives a lone completion holds at 0 and sets the sticky `err_unf_o`.
- R5: Each threshold field has its own disarm code: the vector-memory field is 4 bits with 0xF as the disarm code, the export field is 3 bits with 0x7, and the local field is 5 bits with 0x1F. A disarmed class never holds up ready.
- R6: After dispatch and before the wait executes, all thresholds are unset and `ready_o` stays 0 whatever the counts are.
- R7: An armed class is met when its count is less than or equal to its threshold. Ready requires every armed class to be met in the same cycle.
- R8: `ready_o` rises one cycle after the satisfied condition first holds and lasts exactly one cycle. On that edge `waiting_o` returns to 0 and the thresholds return to unset.
- R9: A wait that executes with all three fields at their disarm codes completes, and `ready_o` pulses in the cycle after the load.
- R10: A threshold load is legal only while waiting and only when no earlier load is still pending. An illegal load is ignored and sets the sticky `err_load_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 3 | Issue strobes, one per class |
| done_i | input | 3 | Completion strobes, one per class |
| wait_dispatch_i | input | 1 | Wait dispatched; context enters waiting |
| wait_exec_i | input | 1 | Wait executes; thresholds load |
| vm_thr_i | input | 4 | Vector-memory threshold (0xF = disarm) |
| ex_thr_i | input | 3 | Export threshold (0x7 = disarm) |
| lc_thr_i | input | 5 | Local/constant/message threshold (0x1F = disarm) |
| vm_count_o | output | 6 | Vector-memory operations in flight |
| ex_count_o | output | 6 | Export operations in flight |
| lc_count_o | output | 6 | Local/constant/message operations in flight |
| waiting_o | output | 1 | Context is in the waiting state |
| ready_o | output | 1 | One-cycle pulse: the wait is satisfied |
| err_load_o | output | 1 | Sticky: illegal threshold load |
| err_ovf_o | output | 1 | Sticky: a counter saturated |
| err_unf_o | output | 1 | Sticky: completion arrived at count 0 |

## Verification
The assertions assume the strobes describe real traffic. Dispatch comes only while running, and the wait-execute strobe follows dispatch in a later cycle. The only exceptions are the deliberate misuse cases covered by R10, R3 and R4.

The directed stimulus keeps to these rules. It drives illegal loads, overflow and underflow only in dedicated scenarios, each of which begins from a fresh reset. This keeps the sticky error flags from masking results in the scenarios that follow.

// File: rtl/wait_trk_pkg.sv
// Package: shared class indices and context state for the wait tracker.
package wait_trk_pkg;
    localparam int NUM_CAT = 3;
    localparam int CAT_VM  = 0;
    localparam int CAT_EX  = 1;
    localparam int CAT_LC  = 2;

    typedef enum logic {
        CTX_RUN  = 1'b0,
        CTX_WAIT = 1'b1
    } ctx_state_e;
endpackage

// File: rtl/wt_counter.sv
// Module: wt_counter
// Saturating up/down counter of operations in flight for one class.
// Assumes: inc and dec are single-cycle strobes. Both strobes together
// cancel out. Overflow and underflow hold the count and set sticky flags.
module wt_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             ovf_err,
    output logic             unf_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count update with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && count != CNT_MAX) begin
            count <= count + 1'b1;
        end else if (dec && !inc && count != '0) begin
            count <= count - 1'b1;
        end
    end

    // Sticky error capture for saturation events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            if (inc && !dec && count == CNT_MAX) ovf_err <= 1'b1;
            if (dec && !inc && count == '0)      unf_err <= 1'b1;
        end
    end

    // R2
    balanced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(count));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && count == CNT_MAX) |=> (count == CNT_MAX && ovf_err));
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && count == '0) |=> (count == '0 && unf_err));
endmodule

// File: rtl/wt_threshold.sv
// Module: wt_threshold
// Holds one class threshold with its armed flag and reports whether the
// class is met. Assumes FIELD_W <= CNT_W. The all-ones code disarms.
module wt_threshold #(
    parameter int FIELD_W = 4,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               clear,
    input  logic [FIELD_W-1:0] code,
    input  logic [CNT_W-1:0]   count,
    output logic               armed,
    output logic               met
);
    localparam logic [FIELD_W-1:0] OFF_CODE = '1;

    logic [FIELD_W-1:0] thr_q;

    // Threshold register: load arms unless disarm code; clear unsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
            armed <= 1'b0;
        end else if (clear) begin
            armed <= 1'b0;
        end else if (load) begin
            thr_q <= code;
            armed <= (code != OFF_CODE);
        end
    end

    // Met when unarmed or in-flight count within the threshold.
    always_comb begin
        met = !armed || (count <= CNT_W'(thr_q));
    end

    // R5
    disarm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear && code == OFF_CODE) |=> !armed);
endmodule

// File: rtl/mem_wait_tracker.sv
// Module: mem_wait_tracker
// Tracks in-flight memory operations in three classes for one context and
// resolves wait instructions. Assumes decode raises wait_dispatch_i only
// while running and wait_exec_i in a later cycle. Misuse is flagged.
module mem_wait_tracker
    import wait_trk_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int VM_W  = 4,
    parameter int EX_W  = 3,
    parameter int LC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        issue_i,
    input  logic [2:0]        done_i,
    input  logic              wait_dispatch_i,
    input  logic              wait_exec_i,
    input  logic [VM_W-1:0]   vm_thr_i,
    input  logic [EX_W-1:0]   ex_thr_i,
    input  logic [LC_W-1:0]   lc_thr_i,
    output logic [CNT_W-1:0]  vm_count_o,
    output logic [CNT_W-1:0]  ex_count_o,
    output logic [CNT_W-1:0]  lc_count_o,
    output logic              waiting_o,
    output logic              ready_o,
    output logic              err_load_o,
    output logic              err_ovf_o,
    output logic              err_unf_o
);
    logic [CNT_W-1:0]   cnt_w [NUM_CAT];
    logic [NUM_CAT-1:0] ovf_w;
    logic [NUM_CAT-1:0] unf_w;
    logic [NUM_CAT-1:0] armed_w;
    logic [NUM_CAT-1:0] met_w;

    ctx_state_e state_q;
    logic       executed_q;
    logic       load_ok;
    logic       sat;

    // One counter per class.
    for (genvar g = 0; g < NUM_CAT; g++) begin : g_cnt
        wt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (issue_i[g]),
            .dec     (done_i[g]),
            .count   (cnt_w[g]),
            .ovf_err (ovf_w[g]),
            .unf_err (unf_w[g])
        );
    end

    wt_threshold #(.FIELD_W(VM_W), .CNT_W(CNT_W)) u_thr_vm (
        .clk(clk), .rst_n(rst_n), .load(load_ok), .clear(sat),
        .code(vm_thr_i), .count(cnt_w[CAT_VM]),
        .armed(armed_w[CAT_VM]), .met(met_w[CAT_VM])
    );
    wt_threshold #(.FIELD_W(EX_W), .CNT_W(CNT_W)) u_thr_ex (
        .clk(clk), .rst_n(rst_n), .load(load_ok), .clear(sat),
        .code(ex_thr_i), .count(cnt_w[CAT_EX]),
        .armed(armed_w[CAT_EX]), .met(met_w[CAT_EX])
    );
    wt_threshold #(.FIELD_W(LC_W), .CNT_W(CNT_W)) u_thr_lc (
        .clk(clk), .rst_n(rst_n), .load(load_ok), .clear(sat),
        .code(lc_thr_i), .count(cnt_w[CAT_LC]),
        .armed(armed_w[CAT_LC]), .met(met_w[CAT_LC])
    );

    // Legality of a load and the satisfied condition.
    always_comb begin
        load_ok = wait_exec_i && (state_q == CTX_WAIT) && !executed_q
                  && (armed_w == '0);
        sat     = (state_q == CTX_WAIT) && executed_q && (&met_w);
    end

    // Context state, executed flag and registered ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CTX_RUN;
            executed_q <= 1'b0;
            ready_o    <= 1'b0;
        end else begin
            ready_o <= sat;
            if (sat) begin
                state_q    <= CTX_RUN;
                executed_q <= 1'b0;
            end else begin
                if (wait_dispatch_i && state_q == CTX_RUN) state_q <= CTX_WAIT;
                if (load_ok) executed_q <= 1'b1;
            end
        end
    end

    // Sticky flag for illegal threshold loads.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_load_o <= 1'b0;
        else if (wait_exec_i && !load_ok) err_load_o <= 1'b1;
    end

    // Output aggregation.
    always_comb begin
        vm_count_o = cnt_w[CAT_VM];
        ex_count_o = cnt_w[CAT_EX];
        lc_count_o = cnt_w[CAT_LC];
        waiting_o  = (state_q == CTX_WAIT);
        err_ovf_o  = |ovf_w;
        err_unf_o  = |unf_w;
    end

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);
    // R8
    ready_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !waiting_o);
    // R6
    ready_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_o && !executed_q) |=> !ready_o);
    // R10
    bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_exec_i && !waiting_o) |=> err_load_o);
endmodule

// File: tb/sim_mem_wait_tracker.sv
`timescale 1ns/1ps
module sim_mem_wait_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] issue_i = '0;
    logic [2:0] done_i = '0;
    logic       wait_dispatch_i = 1'b0;
    logic       wait_exec_i = 1'b0;
    logic [3:0] vm_thr_i = '1;
    logic [2:0] ex_thr_i = '1;
    logic [4:0] lc_thr_i = '1;
    logic [5:0] vm_count_o, ex_count_o, lc_count_o;
    logic       waiting_o, ready_o, err_load_o, err_ovf_o, err_unf_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mem_wait_tracker u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .done_i(done_i),
        .wait_dispatch_i(wait_dispatch_i), .wait_exec_i(wait_exec_i),
        .vm_thr_i(vm_thr_i), .ex_thr_i(ex_thr_i), .lc_thr_i(lc_thr_i),
        .vm_count_o(vm_count_o), .ex_count_o(ex_count_o), .lc_count_o(lc_count_o),
        .waiting_o(waiting_o), .ready_o(ready_o), .err_load_o(err_load_o),
        .err_ovf_o(err_ovf_o), .err_unf_o(err_unf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one edge; outputs then reflect that edge. Strobes drop after.
    task automatic tick();
        @(posedge clk);
        #1;
        issue_i = '0; done_i = '0;
        wait_dispatch_i = 1'b0; wait_exec_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic load_wait(input logic [3:0] v, input logic [2:0] e, input logic [4:0] l);
        wait_exec_i = 1'b1; vm_thr_i = v; ex_thr_i = e; lc_thr_i = l;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 vm count", vm_count_o, 0);
        chk("R1 ex count", ex_count_o, 0);
        chk("R1 lc count", lc_count_o, 0);
        chk("R1 waiting", waiting_o, 0);
        chk("R1 ready", ready_o, 0);
        chk("R1 errors", {err_load_o, err_ovf_o, err_unf_o}, 0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 3; i++) begin issue_i = 3'b001; tick(); end
        for (int i = 0; i < 2; i++) begin issue_i = 3'b010; tick(); end
        for (int i = 0; i < 5; i++) begin issue_i = 3'b100; tick(); end
        chk("R2 vm after 3 issues", vm_count_o, 3);
        chk("R2 ex after 2 issues", ex_count_o, 2);
        chk("R2 lc after 5 issues", lc_count_o, 5);
        issue_i = 3'b001; done_i = 3'b001; tick();
        chk("R2 issue+done unchanged", vm_count_o, 3);
        done_i = 3'b001; tick();
        chk("R2 vm after completion", vm_count_o, 2);
    endtask

    task automatic t_wait_basic();
        wait_dispatch_i = 1'b1; tick();
        chk("R6 waiting after dispatch", waiting_o, 1);
        tick(); tick();
        chk("R6 no ready before exec", ready_o, 0);
        load_wait(4'h1, 3'h7, 5'h1F);
        chk("R7 vm 2 > 1 not ready", ready_o, 0);
        tick();
        chk("R7 still blocked", ready_o, 0);
        done_i = 3'b001; tick();
        chk("R8 ready not in same cycle", ready_o, 0);
        tick();
        chk("R8 ready one cycle later", ready_o, 1);
        chk("R5 disarmed ex/lc ignored, back to running", waiting_o, 0);
        tick();
        chk("R8 ready single pulse", ready_o, 0);
    endtask

    task automatic t_multi();
        wait_dispatch_i = 1'b1; tick();
        load_wait(4'hF, 3'h1, 5'h04);
        tick();
        chk("R7 both armed unmet", ready_o, 0);
        done_i = 3'b010; tick(); tick();
        chk("R7 ex met but lc unmet", ready_o, 0);
        done_i = 3'b100; tick();
        tick();
        chk("R7 all met at equality", ready_o, 1);
        chk("R10 no load error on legal loads", err_load_o, 0);
    endtask

    task automatic t_all_disarm();
        wait_dispatch_i = 1'b1; tick();
        load_wait(4'hF, 3'h7, 5'h1F);
        chk("R9 not ready at load edge", ready_o, 0);
        tick();
        chk("R9 ready after all-disarm load", ready_o, 1);
    endtask

    task automatic t_bad_load();
        do_reset();
        load_wait(4'h0, 3'h0, 5'h00);
        chk("R10 exec while running flagged", err_load_o, 1);
        chk("R10 still running", waiting_o, 0);
        tick();
        chk("R10 ignored load gives no ready", ready_o, 0);
        do_reset();
        issue_i = 3'b001; tick();
        wait_dispatch_i = 1'b1; tick();
        load_wait(4'h0, 3'h7, 5'h1F);
        chk("R10 first load legal", err_load_o, 0);
        load_wait(4'h5, 3'h7, 5'h1F);
        chk("R10 second load flagged", err_load_o, 1);
        tick();
        chk("R10 second load ignored", ready_o, 0);
        done_i = 3'b001; tick(); tick();
        chk("R10 first threshold governs", ready_o, 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 63; i++) begin issue_i = 3'b010; tick(); end
        chk("R3 count reaches 63", ex_count_o, 63);
        chk("R3 no overflow yet", err_ovf_o, 0);
        issue_i = 3'b010; tick();
        chk("R3 count holds 63", ex_count_o, 63);
        chk("R3 overflow flag", err_ovf_o, 1);
    endtask

    task automatic t_underflow();
        do_reset();
        done_i = 3'b100; tick();
        chk("R4 count holds 0", lc_count_o, 0);
        chk("R4 underflow flag", err_unf_o, 1);
        tick();
        chk("R4 underflow sticky", err_unf_o, 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_count();
        t_wait_basic();
        t_multi();
        t_all_disarm();
        t_bad_load();
        t_overflow();
        t_underflow();
        finish_run();
    end
endmodule